// File: doc/BRIEF.md
# Dual-Granularity Condition Register File

This block holds a 32-bit condition word as eight separate 4-bit fields, numbered 0 to 7, each kept in its own bank with its own write enable and its own read enable. A client reaches the fields in one of two ways. The wide path moves the whole 32-bit word in a single cycle by enabling every bank together. The narrow path moves one 4-bit field, chosen by a one-hot enable vector, on a 4-bit data bus.

The mapping from fields to bits on the wide path is fixed wiring. Field n sits at bits 4n+3 down to 4n. The narrow path returns field n for enable bit n no matter where that field lands in the wide word.

A helper port takes a 5-bit condition-bit index and returns one condition bit. The index's upper three bits name the field and its lower two bits name the bit inside that field.

Wide and narrow traffic must never share a cycle. The block flags any illegal enable pattern and refuses to write during that cycle. Writes commit on the rising clock edge. Reads are combinational from the stored banks.

Top module: `cond_reg_file`

## Requirements
- R1: A synchronous active-low reset clears all eight fields to zero. After reset, a wide read returns 0 and a narrow read of any field returns 0.
- R2: With `wide_wr_en` high and no protocol error, all 32 bits of `wide_wdata` are stored at the rising edge. A wide read in a later cycle returns that word.
- R3: On the wide path, field n occupies bits [4n+3:4n]. Field 0 is in bits 3..0 and field 7 is in bits 31..28.
- R4: A narrow write with exactly one bit n of `narrow_wr_en` set, and no protocol error, stores `narrow_wdata` into field n only. All other fields keep their values.
- R5: A narrow read with exactly one bit n of `narrow_rd_en` set, and no protocol error, drives field n's contents on `narrow_rdata`.
- R6: Reads are combinational from stored contents. A read in the same cycle as a write returns the old value, and the new value appears from the next cycle. A read output whose enable is low reads as 0.
- R7: If more than one bit of `narrow_wr_en`, or more than one bit of `narrow_rd_en`, is set, `proto_err` is 1 in that cycle and no field changes.
- R8: If any wide enable and any narrow enable are high in the same cycle, `proto_err` is 1 and no field changes.
- R9: `bit_out` equals bit `bit_idx[1:0]` of field `bit_idx[4:2]`. This is bit `bit_idx` of the wide word. It does not depend on any enable.
- R10: While `proto_err` is 1, both `wide_rdata` and `narrow_rdata` read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_rd_en | input | 1 | Read all eight fields on the wide path |
| wide_wr_en | input | 1 | Write all eight fields from the wide path |
| wide_wdata | input | 32 | Wide write word, field n at bits 4n+3..4n |
| wide_rdata | output | 32 | Wide read word, field n at bits 4n+3..4n |
| narrow_rd_en | input | 8 | One-hot narrow read select, bit n selects field n |
| narrow_wr_en | input | 8 | One-hot narrow write select, bit n selects field n |
| narrow_wdata | input | 4 | Narrow write data |
| narrow_rdata | output | 4 | Narrow read data |
| bit_idx | input | 5 | Condition-bit index: [4:2] field, [1:0] bit in field |
| bit_out | output | 1 | Selected condition bit |
| proto_err | output | 1 | Illegal enable combination in this cycle |

## Verification
The wide path is tested with an asymmetric word whose nibbles are all different. This catches a swapped or reversed field order. It is followed by an all-ones word, which makes a single-field narrow clear stand out against its neighbours. Narrow reads sweep every field against that word. Narrow writes to fields 0, 4 and 7 are then read back wide, which separates writes that land in the correct field from writes that land elsewhere or spill into adjacent fields. Illegal patterns are tried one at a time: two narrow writes, two narrow reads, wide plus narrow write, and wide plus narrow read. Each is followed by a clean wide read, which shows that no partial write slipped through. The bit index is tried at both ends of the word and at mid-field positions.

// File: rtl/crf_pkg.sv
// Package: crf_pkg
// Shared sizing for the condition register file. Every module derives its
// widths from these two values so the geometry is stated in one place.
package crf_pkg;
    parameter int FIELD_W    = 4;
    parameter int NUM_FIELDS = 8;
    localparam int WORD_W    = FIELD_W * NUM_FIELDS;
    localparam int IDX_W     = $clog2(WORD_W);
    localparam int FSEL_W    = $clog2(NUM_FIELDS);
    localparam int BSEL_W    = $clog2(FIELD_W);
endpackage

// File: rtl/crf_bank.sv
// Module: crf_bank
// One field of storage: a FIELD_W-bit register with its own write enable.
// Assumes the enable is already qualified (legal access, no error).
module crf_bank #(
    parameter int FIELD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [FIELD_W-1:0] d,
    output logic [FIELD_W-1:0] q
);
    // Hold the field; clear on reset, load on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/crf_guard.sv
// Module: crf_guard
// Checks the enable pattern of a cycle and turns the raw requests into
// per-bank write strobes and qualified read selects. Assumes enables are
// sampled in the same cycle they are presented; it holds no state.
module crf_guard #(
    parameter int NUM_FIELDS = 8
) (
    input  logic                  wide_rd_en,
    input  logic                  wide_wr_en,
    input  logic [NUM_FIELDS-1:0] narrow_rd_en,
    input  logic [NUM_FIELDS-1:0] narrow_wr_en,
    output logic                  err,
    output logic                  wide_rd_ok,
    output logic                  wide_wr_ok,
    output logic [NUM_FIELDS-1:0] narrow_rd_ok,
    output logic [NUM_FIELDS-1:0] bank_we
);
    localparam int CNT_W = $clog2(NUM_FIELDS + 1);

    logic [CNT_W-1:0] wr_cnt;
    logic [CNT_W-1:0] rd_cnt;
    logic             multi_hot;
    logic             mixed;

    // Count asserted narrow enables for the one-hot rule.
    always_comb begin
        wr_cnt = '0;
        rd_cnt = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            wr_cnt = wr_cnt + CNT_W'(narrow_wr_en[i]);
            rd_cnt = rd_cnt + CNT_W'(narrow_rd_en[i]);
        end
    end

    // Classify the cycle as legal or erroneous.
    always_comb begin
        multi_hot = (wr_cnt > CNT_W'(1)) || (rd_cnt > CNT_W'(1));
        mixed     = (wide_rd_en || wide_wr_en) && ((|narrow_rd_en) || (|narrow_wr_en));
        err       = multi_hot || mixed;
    end

    // Qualify requests: nothing moves in an erroneous cycle.
    always_comb begin
        wide_rd_ok   = wide_rd_en && !err;
        wide_wr_ok   = wide_wr_en && !err;
        narrow_rd_ok = err ? '0 : narrow_rd_en;
        bank_we      = err ? '0 : (narrow_wr_en | {NUM_FIELDS{wide_wr_en}});
    end
endmodule

// File: rtl/crf_bit_pick.sv
// Module: crf_bit_pick
// Returns one condition bit from the packed word: the index's upper bits
// pick the field, its low bits pick the bit inside it. Assumes field n is
// packed at bits [n*FIELD_W +: FIELD_W].
module crf_bit_pick #(
    parameter int FIELD_W    = 4,
    parameter int NUM_FIELDS = 8,
    localparam int WORD_W    = FIELD_W * NUM_FIELDS,
    localparam int IDX_W     = $clog2(WORD_W),
    localparam int BSEL_W    = $clog2(FIELD_W),
    localparam int FSEL_W    = $clog2(NUM_FIELDS)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic              bit_q
);
    logic [FSEL_W-1:0]  fsel;
    logic [BSEL_W-1:0]  bsel;
    logic [FIELD_W-1:0] field_q;

    // Split the index into field and bit parts.
    always_comb begin
        fsel = idx[IDX_W-1:BSEL_W];
        bsel = idx[BSEL_W-1:0];
    end

    // Select the addressed field.
    always_comb begin
        field_q = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (fsel == FSEL_W'(f)) begin
                field_q = word[f*FIELD_W +: FIELD_W];
            end
        end
    end

    // Select the bit within the field.
    always_comb begin
        bit_q = field_q[bsel];
    end
endmodule

// File: rtl/cond_reg_file.sv
// Module: cond_reg_file
// Condition register file of NUM_FIELDS banks, each FIELD_W bits wide.
// It has a wide path that covers all banks at once, a one-hot narrow path
// for a single bank, and a single-bit read helper. Assumes the client
// keeps wide and narrow traffic in separate cycles; any violation is
// flagged on proto_err and blocks writes for that cycle.
module cond_reg_file
    import crf_pkg::*;
#(
    parameter int FIELD_W    = crf_pkg::FIELD_W,
    parameter int NUM_FIELDS = crf_pkg::NUM_FIELDS,
    localparam int WORD_W    = FIELD_W * NUM_FIELDS,
    localparam int IDX_W     = $clog2(WORD_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wide_rd_en,
    input  logic                  wide_wr_en,
    input  logic [WORD_W-1:0]     wide_wdata,
    output logic [WORD_W-1:0]     wide_rdata,
    input  logic [NUM_FIELDS-1:0] narrow_rd_en,
    input  logic [NUM_FIELDS-1:0] narrow_wr_en,
    input  logic [FIELD_W-1:0]    narrow_wdata,
    output logic [FIELD_W-1:0]    narrow_rdata,
    input  logic [IDX_W-1:0]      bit_idx,
    output logic                  bit_out,
    output logic                  proto_err
);
    logic                  wide_rd_ok;
    logic                  wide_wr_ok;
    logic [NUM_FIELDS-1:0] narrow_rd_ok;
    logic [NUM_FIELDS-1:0] bank_we;
    logic [WORD_W-1:0]     store_word;

    crf_guard #(
        .NUM_FIELDS (NUM_FIELDS)
    ) u_guard (
        .wide_rd_en   (wide_rd_en),
        .wide_wr_en   (wide_wr_en),
        .narrow_rd_en (narrow_rd_en),
        .narrow_wr_en (narrow_wr_en),
        .err          (proto_err),
        .wide_rd_ok   (wide_rd_ok),
        .wide_wr_ok   (wide_wr_ok),
        .narrow_rd_ok (narrow_rd_ok),
        .bank_we      (bank_we)
    );

    // One bank per field; the wide slice is hard-wired to field position.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_bank
        logic [FIELD_W-1:0] bank_d;

        // Choose the write source for this bank.
        always_comb begin
            bank_d = wide_wr_ok ? wide_wdata[g*FIELD_W +: FIELD_W] : narrow_wdata;
        end

        crf_bank #(
            .FIELD_W (FIELD_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[g]),
            .d     (bank_d),
            .q     (store_word[g*FIELD_W +: FIELD_W])
        );
    end

    // Wide read: whole word when qualified, zero otherwise.
    always_comb begin
        wide_rdata = wide_rd_ok ? store_word : '0;
    end

    // Narrow read: AND-OR mux over the one-hot qualified selects.
    always_comb begin
        narrow_rdata = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            narrow_rdata = narrow_rdata
                         | (store_word[f*FIELD_W +: FIELD_W] & {FIELD_W{narrow_rd_ok[f]}});
        end
    end

    crf_bit_pick #(
        .FIELD_W    (FIELD_W),
        .NUM_FIELDS (NUM_FIELDS)
    ) u_bit_pick (
        .word  (store_word),
        .idx   (bit_idx),
        .bit_q (bit_out)
    );
endmodule

// File: rtl/crf_checker.sv
// Module: crf_checker
// Protocol and storage properties for cond_reg_file, attached by bind.
// Observes the ports plus the packed bank contents.
module crf_checker #(
    parameter int FIELD_W    = 4,
    parameter int NUM_FIELDS = 8,
    localparam int WORD_W    = FIELD_W * NUM_FIELDS,
    localparam int IDX_W     = $clog2(WORD_W)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wide_wr_en,
    input logic [WORD_W-1:0]     wide_wdata,
    input logic [WORD_W-1:0]     wide_rdata,
    input logic [NUM_FIELDS-1:0] narrow_wr_en,
    input logic [FIELD_W-1:0]    narrow_wdata,
    input logic [FIELD_W-1:0]    narrow_rdata,
    input logic [IDX_W-1:0]      bit_idx,
    input logic                  bit_out,
    input logic                  proto_err,
    input logic [WORD_W-1:0]     store_word
);
    logic [WORD_W-1:0] wr_mask;
    logic [WORD_W-1:0] wdata_spread;

    // Expand narrow write enables and data to word positions.
    always_comb begin
        for (int f = 0; f < NUM_FIELDS; f++) begin
            wr_mask[f*FIELD_W +: FIELD_W]      = {FIELD_W{narrow_wr_en[f]}};
            wdata_spread[f*FIELD_W +: FIELD_W] = narrow_wdata;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> store_word == '0);

    // R2
    wide_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_wr_en && !proto_err) |=> store_word == $past(wide_wdata));

    // R4
    narrow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_wr_en && !proto_err && (|narrow_wr_en)) |=>
        store_word == (($past(store_word) & ~$past(wr_mask)) | ($past(wdata_spread) & $past(wr_mask))));

    // R7
    onehot_when_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !proto_err |-> $onehot0(narrow_wr_en));

    // R8
    err_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> $stable(store_word));

    // R9
    bit_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_out == store_word[bit_idx]);

    // R10
    err_quiets_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (wide_rdata == '0 && narrow_rdata == '0));
endmodule

bind cond_reg_file crf_checker #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS)
) u_crf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_wr_en   (wide_wr_en),
    .wide_wdata   (wide_wdata),
    .wide_rdata   (wide_rdata),
    .narrow_wr_en (narrow_wr_en),
    .narrow_wdata (narrow_wdata),
    .narrow_rdata (narrow_rdata),
    .bit_idx      (bit_idx),
    .bit_out      (bit_out),
    .proto_err    (proto_err),
    .store_word   (store_word)
);

// File: tb/test_cond_reg_file.sv
module test_cond_reg_file;
    localparam int CLK_PERIOD = 10;

    localparam int SEL_WIDE   = 0;
    localparam int SEL_NARROW = 1;
    localparam int SEL_BIT    = 2;
    localparam int SEL_ERR    = 3;

    typedef struct {
        int          req;
        int          sel;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_rd_en = 1'b0;
    logic        wide_wr_en = 1'b0;
    logic [31:0] wide_wdata = '0;
    logic [31:0] wide_rdata;
    logic [7:0]  narrow_rd_en = '0;
    logic [7:0]  narrow_wr_en = '0;
    logic [3:0]  narrow_wdata = '0;
    logic [3:0]  narrow_rdata;
    logic [4:0]  bit_idx = '0;
    logic        bit_out;
    logic        proto_err;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [31:0] model = '0;
    item_t       sb_q[$];
    event        sample_ev;

    cond_reg_file i_cond_reg_file (
        .clk          (clk),
        .rst_n        (rst_n),
        .wide_rd_en   (wide_rd_en),
        .wide_wr_en   (wide_wr_en),
        .wide_wdata   (wide_wdata),
        .wide_rdata   (wide_rdata),
        .narrow_rd_en (narrow_rd_en),
        .narrow_wr_en (narrow_wr_en),
        .narrow_wdata (narrow_wdata),
        .narrow_rdata (narrow_rdata),
        .bit_idx      (bit_idx),
        .bit_out      (bit_out),
        .proto_err    (proto_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    SEL_WIDE:   act = wide_rdata;
                    SEL_NARROW: act = {28'd0, narrow_rdata};
                    SEL_BIT:    act = {31'd0, bit_out};
                    default:    act = {31'd0, proto_err};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input int req, input int sel, input logic [31:0] exp);
        item_t it;
        it.req = req;
        it.sel = sel;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic drive_idle();
        wide_rd_en   = 1'b0;
        wide_wr_en   = 1'b0;
        narrow_rd_en = '0;
        narrow_wr_en = '0;
    endtask

    task automatic post();
        #1;
        ->sample_ev;
        #0;
    endtask

    // R1 R2 R3: wide read of the whole word
    task automatic wide_read(input int req);
        @(negedge clk);
        drive_idle();
        wide_rd_en = 1'b1;
        expect_item(req, SEL_WIDE, model);
        expect_item(req, SEL_ERR, 32'd0);
        post();
    endtask

    // R6: wide write with a same-cycle read sees the old word
    task automatic wide_write(input logic [31:0] d);
        @(negedge clk);
        drive_idle();
        wide_wr_en = 1'b1;
        wide_rd_en = 1'b1;
        wide_wdata = d;
        expect_item(6, SEL_WIDE, model);
        expect_item(2, SEL_ERR, 32'd0);
        post();
        model = d;
    endtask

    task automatic narrow_write(input int f, input logic [3:0] d);
        @(negedge clk);
        drive_idle();
        narrow_wr_en[f] = 1'b1;
        narrow_wdata    = d;
        expect_item(4, SEL_ERR, 32'd0);
        post();
        model[f*4 +: 4] = d;
    endtask

    // R5 R3: narrow read of one field
    task automatic narrow_read(input int f, input int req);
        @(negedge clk);
        drive_idle();
        narrow_rd_en[f] = 1'b1;
        expect_item(req, SEL_NARROW, {28'd0, model[f*4 +: 4]});
        post();
    endtask

    // R9: one condition bit
    task automatic bit_read(input logic [4:0] idx);
        @(negedge clk);
        drive_idle();
        bit_idx = idx;
        expect_item(9, SEL_BIT, {31'd0, model[idx]});
        post();
    endtask

    // R7 R8 R10: illegal pattern flags, quiets reads, writes nothing
    task automatic bad_access(input int req, input logic wr, input logic wd_rd,
                              input logic [7:0] nwr, input logic [7:0] nrd);
        @(negedge clk);
        drive_idle();
        wide_wr_en   = wr;
        wide_rd_en   = wd_rd;
        wide_wdata   = ~model;
        narrow_wr_en = nwr;
        narrow_rd_en = nrd;
        narrow_wdata = ~model[3:0];
        expect_item(req, SEL_ERR, 32'd1);
        expect_item(10, SEL_WIDE, 32'd0);
        expect_item(10, SEL_NARROW, 32'd0);
        post();
        wide_read(req);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state through both paths
        wide_read(1);
        narrow_read(3, 1);

        // R6: read output with enable low is zero
        @(negedge clk);
        drive_idle();
        wide_wdata = 32'hFFFF_FFFF;
        expect_item(6, SEL_WIDE, 32'd0);
        expect_item(6, SEL_NARROW, 32'd0);
        post();

        // R2 R6: wide write, visible next cycle
        wide_write(32'hA5C3_9E71);
        wide_read(2);

        // R3 R5: sweep all fields on the narrow path
        for (int f = 0; f < 8; f++) begin
            narrow_read(f, 3);
        end

        // R4: narrow writes at both ends and the middle
        narrow_write(0, 4'hF);
        narrow_write(7, 4'h2);
        narrow_write(4, 4'h6);
        wide_read(4);
        narrow_read(7, 5);

        // R9: bit index at ends and mid-field
        bit_read(5'd0);
        bit_read(5'd31);
        bit_read(5'd13);
        bit_read(5'd6);
        bit_read(5'd18);

        // R7 R8 R10: illegal patterns
        bad_access(7, 1'b0, 1'b0, 8'b0000_0011, 8'b0000_0000);
        bad_access(7, 1'b0, 1'b0, 8'b0000_0000, 8'b1010_0000);
        bad_access(8, 1'b1, 1'b0, 8'b0000_0100, 8'b0000_0000);
        bad_access(8, 1'b0, 1'b1, 8'b0000_0000, 8'b0010_0000);

        // R4: single-field clear against all ones
        wide_write(32'hFFFF_FFFF);
        narrow_write(5, 4'h0);
        wide_read(4);
        bit_read(5'd21);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        wide_read(1);

        @(negedge clk);
        drive_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule